// File: doc/BRIEF.md
# Typed Matrix Tile Register File

This block holds a square two-dimensional array of bytes: VL/8 horizontal slices, each VL bits wide, for (VL/8)×(VL/8) bytes in total. Matrix and outer-product engines use it as an accumulator store. The same physical slices can be seen as a single byte-element tile. They can also be seen as 2, 4 or 8 interleaved tiles of 16, 32 or 64-bit elements. A caller picks an element size, a tile number and a row number that arrive at run time. The block maps that triple onto one physical slice. It then returns the slice on a VL-bit read bus and, when asked, writes it under a per-byte mask.

In the 32-bit view the caller can also address a column. A column read collects one 32-bit element from every row of the selected tile into a single VL-bit word. A column write spreads a word back over those elements. A single-cycle clear input wipes the whole store.

Top module: `mtile_regfile`

## Requirements
- R1: After reset every byte of the store reads as zero.
- R2: Element-size code `esize_sel` selects 8-bit (0), 16-bit (1), 32-bit (2) or 64-bit (3) elements. For code k there are T = 2^k tiles of VL/8/T rows each. Tile t, row r maps to physical slice r*T + t.
- R3: In the 8-bit view the row number is the physical slice index, so the whole array is reachable as plain slices 0 to VL/8-1.
- R4: In the 16-bit view tile 0 sits on the even slices and tile 1 on the odd slices. In the 32-bit view row 0 of tiles 0, 1, 2 and 3 is physical slices 0, 1, 2 and 3.
- R5: A tile or row number beyond the range for the selected element size is reduced modulo that range (its low bits are kept). No error is raised.
- R6: On a write, byte k of the target (bits 8k+7..8k) changes only when `wbe[k]` is 1. A write with an all-zero mask changes nothing.
- R7: A write takes effect at the rising clock edge. A read of the same slice in that cycle shows the previous contents, and the following cycle shows the new contents.
- R8: `clear_all` zeroes the entire store at the next edge and wins over a write in the same cycle.
- R9: With `col_mode` set in the 32-bit view, the read word's element i (bits 32i+31..32i) is element c of row i of the selected tile, where c is the row number modulo VL/32.
- R10: With `col_mode` set in the 32-bit view, a write stores element i of `wdata` into element c of row i of the tile. Each element uses its own four `wbe` bits (bits 4i to 4i+3).
- R11: `col_mode` is ignored for 8, 16 and 64-bit element sizes, and the access is horizontal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_all | input | 1 | Zero the entire store at the next edge |
| esize_sel | input | 2 | Element size code: 0=8, 1=16, 2=32, 3=64 bits |
| tile_sel | input | 3 | Tile number within the selected view |
| row_sel | input | log2(VL/8) | Row number within the tile (column index in column mode) |
| col_mode | input | 1 | Column access, honoured in the 32-bit view only |
| wr_en | input | 1 | Write the addressed slice or column |
| wdata | input | VL | Write data |
| wbe | input | VL/8 | Per-byte write enable |
| rdata | output | VL | Read data for the current address |

## Verification
Ordinary traffic does not easily reach the case where two views alias each other. That case is a write made through a wide-element tile or a column, then read back through a different view onto the same physical bytes. The random stimulus draws element size, tile, row, column mode and mask independently on every cycle and uses over-range tile and row numbers freely. Writes through one view are therefore read back through the others. Directed steps cover the remaining cases: the byte view after a 16-bit odd-tile write, a column write followed by row reads, and a clear coinciding with a write.

// File: rtl/mtile_pkg.sv
package mtile_pkg;

    typedef enum logic [1:0] {
        ES_BYTE  = 2'd0,
        ES_HALF  = 2'd1,
        ES_WORD  = 2'd2,
        ES_DWORD = 2'd3
    } esize_e;

    localparam int unsigned TILE_W   = 3;
    localparam int unsigned COL_ELEM = 32;

endpackage

// File: rtl/mtile_addr.sv
module mtile_addr
    import mtile_pkg::*;
#(
    parameter int unsigned NS = 16,
    localparam int unsigned SW = $clog2(NS)
) (
    input  logic [1:0]        esize_i,
    input  logic [TILE_W-1:0] tile_i,
    input  logic [SW-1:0]     row_i,
    output logic [TILE_W-1:0] tile_m_o,
    output logic [SW-1:0]     row_m_o,
    output logic [SW-1:0]     phys_o
);

    logic [TILE_W-1:0] tile_mask;
    logic [SW-1:0]     row_mask;

    always_comb begin
        unique case (esize_e'(esize_i))
            ES_BYTE:  tile_mask = 3'b000;
            ES_HALF:  tile_mask = 3'b001;
            ES_WORD:  tile_mask = 3'b011;
            default:  tile_mask = 3'b111;
        endcase
        row_mask = SW'((NS >> esize_i) - 1);
        tile_m_o = tile_i & tile_mask;
        row_m_o  = row_i & row_mask;
        phys_o   = SW'(row_m_o << esize_i) | SW'(tile_m_o);
    end

endmodule

// File: rtl/mtile_col_gather.sv
module mtile_col_gather
    import mtile_pkg::*;
#(
    parameter int unsigned VL_BITS = 128,
    localparam int unsigned NS = VL_BITS / 8,
    localparam int unsigned NW = VL_BITS / COL_ELEM,
    localparam int unsigned CW = $clog2(NW)
) (
    input  logic [NS-1:0][VL_BITS-1:0] mem_i,
    input  logic [1:0]                 tile_i,
    input  logic [CW-1:0]              col_i,
    output logic [VL_BITS-1:0]         col_o
);

    always_comb begin
        col_o = '0;
        for (int i = 0; i < NW; i++) begin
            col_o[i*COL_ELEM +: COL_ELEM] =
                mem_i[i*4 + int'(tile_i)][int'(col_i)*COL_ELEM +: COL_ELEM];
        end
    end

endmodule

// File: rtl/mtile_store.sv
module mtile_store
    import mtile_pkg::*;
#(
    parameter int unsigned VL_BITS = 128,
    localparam int unsigned NS = VL_BITS / 8,
    localparam int unsigned NB = VL_BITS / 8,
    localparam int unsigned SW = $clog2(NS),
    localparam int unsigned NW = VL_BITS / COL_ELEM,
    localparam int unsigned CW = $clog2(NW)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear_i,
    input  logic                       wr_en_i,
    input  logic                       col_wr_i,
    input  logic [SW-1:0]              phys_i,
    input  logic [1:0]                 tile_i,
    input  logic [CW-1:0]              col_i,
    input  logic [VL_BITS-1:0]         wdata_i,
    input  logic [NB-1:0]              wbe_i,
    output logic [NS-1:0][VL_BITS-1:0] mem_o
);

    typedef struct packed {
        logic [NS-1:0][VL_BITS-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.mem = '0;
        end else if (wr_en_i) begin
            if (col_wr_i) begin
                for (int i = 0; i < NW; i++) begin
                    for (int b = 0; b < 4; b++) begin
                        if (wbe_i[i*4 + b]) begin
                            st_d.mem[i*4 + int'(tile_i)][int'(col_i)*COL_ELEM + b*8 +: 8] =
                                wdata_i[i*COL_ELEM + b*8 +: 8];
                        end
                    end
                end
            end else begin
                for (int b = 0; b < NB; b++) begin
                    if (wbe_i[b]) begin
                        st_d.mem[phys_i][b*8 +: 8] = wdata_i[b*8 +: 8];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_o = st_q.mem;

    // R8: a clear leaves every slice zero after the edge
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.mem == '0));

    // R7: without write or clear the store keeps its contents
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !wr_en_i) |=> $stable(st_q.mem));

    // R6: a write with an empty mask changes nothing
    a_r6_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && wr_en_i && (wbe_i == '0)) |=> $stable(st_q.mem));

endmodule

// File: rtl/mtile_regfile.sv
module mtile_regfile
    import mtile_pkg::*;
#(
    parameter int unsigned VL_BITS = 128,
    localparam int unsigned NS = VL_BITS / 8,
    localparam int unsigned NB = VL_BITS / 8,
    localparam int unsigned SW = $clog2(NS),
    localparam int unsigned NW = VL_BITS / COL_ELEM,
    localparam int unsigned CW = $clog2(NW)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_all,
    input  logic [1:0]         esize_sel,
    input  logic [2:0]         tile_sel,
    input  logic [SW-1:0]      row_sel,
    input  logic               col_mode,
    input  logic               wr_en,
    input  logic [VL_BITS-1:0] wdata,
    input  logic [NB-1:0]      wbe,
    output logic [VL_BITS-1:0] rdata
);

    logic [TILE_W-1:0]          tile_m;
    logic [SW-1:0]              row_m;
    logic [SW-1:0]              phys;
    logic                       col_active;
    logic [CW-1:0]              col_idx;
    logic [NS-1:0][VL_BITS-1:0] mem;
    logic [VL_BITS-1:0]         col_word;

    mtile_addr #(.NS(NS)) addr_i (
        .esize_i  (esize_sel),
        .tile_i   (tile_sel),
        .row_i    (row_sel),
        .tile_m_o (tile_m),
        .row_m_o  (row_m),
        .phys_o   (phys)
    );

    assign col_active = col_mode && (esize_e'(esize_sel) == ES_WORD);
    assign col_idx    = CW'(row_m);

    mtile_store #(.VL_BITS(VL_BITS)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_all),
        .wr_en_i  (wr_en),
        .col_wr_i (col_active),
        .phys_i   (phys),
        .tile_i   (tile_m[1:0]),
        .col_i    (col_idx),
        .wdata_i  (wdata),
        .wbe_i    (wbe),
        .mem_o    (mem)
    );

    mtile_col_gather #(.VL_BITS(VL_BITS)) gather_i (
        .mem_i  (mem),
        .tile_i (tile_m[1:0]),
        .col_i  (col_idx),
        .col_o  (col_word)
    );

    assign rdata = col_active ? col_word : mem[phys];

    // R4: halfword tiles 0 and 1 land on even and odd slices
    a_r4_half_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (esize_sel == 2'd1) |-> (phys[0] == tile_sel[0]));

    // R8: after a clear the read bus shows zero
    a_r8_clear_read: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (rdata == '0));

    // R7: a full-mask horizontal write is visible on the next cycle
    a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear_all && (&wbe) && !col_active) ##1
        ($stable(esize_sel) && $stable(tile_sel) && $stable(row_sel) && $stable(col_mode))
        |-> (rdata == $past(wdata)));

endmodule

// File: tb/mtile_regfile_tb_top.sv
`timescale 1ns/1ps
module mtile_regfile_tb_top;

    localparam int unsigned VL = 128;
    localparam int unsigned NS = VL / 8;
    localparam int unsigned NB = VL / 8;
    localparam int unsigned SW = $clog2(NS);
    localparam int unsigned NW = VL / 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear_all = 1'b0;
    logic [1:0]    esize_sel = '0;
    logic [2:0]    tile_sel = '0;
    logic [SW-1:0] row_sel = '0;
    logic          col_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic [VL-1:0] wdata = '0;
    logic [NB-1:0] wbe = '0;
    logic [VL-1:0] rdata;

    int checks = 0;
    int errors = 0;
    logic [VL-1:0] mdl [NS];

    always #2.5 clk = ~clk;

    mtile_regfile #(.VL_BITS(VL)) dut_i (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .esize_sel(esize_sel),
        .tile_sel(tile_sel), .row_sel(row_sel), .col_mode(col_mode), .wr_en(wr_en),
        .wdata(wdata), .wbe(wbe), .rdata(rdata)
    );

    function automatic int map_slice(int es, int t, int r);
        int nt = 1 << es;
        int nr = NS >> es;
        return (r % nr) * nt + (t % nt);
    endfunction

    function automatic logic [VL-1:0] exp_read(int es, int t, int r, bit col);
        logic [VL-1:0] w = '0;
        if (col && es == 2) begin
            for (int i = 0; i < NW; i++)
                w[i*32 +: 32] = mdl[i*4 + (t % 4)][(r % NW)*32 +: 32];
        end else begin
            w = mdl[map_slice(es, t, r)];
        end
        return w;
    endfunction

    function automatic logic [VL-1:0] rand_word();
        logic [VL-1:0] w;
        for (int i = 0; i < NW; i++) w[i*32 +: 32] = $urandom;
        return w;
    endfunction

    task automatic model_update(bit clr, int es, int t, int r, bit col, bit we,
                                logic [VL-1:0] wd, logic [NB-1:0] be);
        if (clr) begin
            for (int s = 0; s < NS; s++) mdl[s] = '0;
        end else if (we) begin
            if (col && es == 2) begin
                for (int i = 0; i < NW; i++)
                    for (int b = 0; b < 4; b++)
                        if (be[i*4 + b])
                            mdl[i*4 + (t % 4)][(r % NW)*32 + b*8 +: 8] = wd[i*32 + b*8 +: 8];
            end else begin
                for (int b = 0; b < NB; b++)
                    if (be[b]) mdl[map_slice(es, t, r)][b*8 +: 8] = wd[b*8 +: 8];
            end
        end
    endtask

    // Drive one cycle, check the read before the edge, then advance the model
    task automatic step(bit clr, int es, int t, int r, bit col, bit we,
                        logic [VL-1:0] wd, logic [NB-1:0] be, string tag);
        logic [VL-1:0] e;
        @(negedge clk);
        clear_all = clr; esize_sel = 2'(es); tile_sel = 3'(t); row_sel = SW'(r);
        col_mode = col; wr_en = we; wdata = wd; wbe = be;
        #1;
        e = exp_read(es, t, r, col);
        checks++;
        if (rdata !== e) begin
            errors++;
            $display("FAIL %s: es=%0d t=%0d r=%0d col=%0b got %h exp %h",
                     tag, es, t, r, col, rdata, e);
        end
        model_update(clr, es, t, r, col, we, wd, be);
    endtask

    task automatic rd(int es, int t, int r, bit col, string tag);
        step(1'b0, es, t, r, col, 1'b0, '0, '0, tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        logic [VL-1:0] a;
        void'($urandom(32'd4242));
        for (int s = 0; s < NS; s++) mdl[s] = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset contents, R3 byte view walks every slice
        for (int s = 0; s < NS; s++) rd(0, 0, s, 1'b0, "R1_R3 reset zero");

        // R4 halfword odd tile lands on slice 1
        a = rand_word();
        step(1'b0, 1, 1, 0, 1'b0, 1'b1, a, '1, "R4 half write");
        rd(0, 0, 1, 1'b0, "R4 byte view of odd slice");
        rd(0, 0, 0, 1'b0, "R4 even slice untouched");
        // R4 word tile 2 row 0 is slice 2
        step(1'b0, 2, 2, 0, 1'b0, 1'b1, rand_word(), '1, "R4 word write");
        rd(0, 0, 2, 1'b0, "R4 byte view of slice 2");
        // R2 dword tile 5 row 1 is slice 13
        step(1'b0, 3, 5, 1, 1'b0, 1'b1, rand_word(), '1, "R2 dword write");
        rd(0, 0, 13, 1'b0, "R2 byte view of slice 13");
        // R5 over-range tile and row wrap
        step(1'b0, 1, 3, NS/2 + 1, 1'b0, 1'b1, rand_word(), '1, "R5 wrapped write");
        rd(0, 0, 3, 1'b0, "R5 wrapped target slice 3");
        rd(2, 6, NS/4 + 0, 1'b0, "R5 word view wrap");
        // R6 partial mask and empty mask
        step(1'b0, 0, 0, 4, 1'b0, 1'b1, '1, 16'h00F0, "R6 partial mask");
        rd(0, 0, 4, 1'b0, "R6 only masked bytes set");
        step(1'b0, 0, 0, 2, 1'b0, 1'b1, '1, '0, "R6 empty mask");
        rd(0, 0, 2, 1'b0, "R6 empty mask no change");
        // R7 same-cycle read shows old, next cycle new
        step(1'b0, 0, 0, 6, 1'b0, 1'b1, rand_word(), '1, "R7 old data during write");
        rd(0, 0, 6, 1'b0, "R7 new data after edge");
        // R9 column read, R10 column write
        rd(2, 1, 2, 1'b1, "R9 column read");
        step(1'b0, 2, 3, 1, 1'b1, 1'b1, rand_word(), 16'hF0FF, "R10 column write");
        for (int s = 0; s < NS; s++) rd(0, 0, s, 1'b0, "R10 rows after column write");
        rd(2, 3, 1, 1'b1, "R10 column readback");
        // R11 column mode ignored outside word view
        step(1'b0, 1, 0, 5, 1'b1, 1'b1, rand_word(), '1, "R11 col ignored write");
        rd(1, 0, 5, 1'b1, "R11 col ignored read");
        rd(0, 0, 10, 1'b0, "R11 byte view of slice 10");
        // R8 clear wins over write
        step(1'b1, 0, 0, 7, 1'b0, 1'b1, '1, '1, "R8 clear with write");
        for (int s = 0; s < NS; s++) rd(0, 0, s, 1'b0, "R8 cleared");

        // Random mix across all views (R2 R5 R6 R9 R10 R11)
        for (int n = 0; n < 4000; n++) begin
            bit clr = (($urandom % 97) == 0);
            int es  = int'($urandom % 4);
            int t   = int'($urandom % 8);
            int r   = int'($urandom % NS);
            bit col = (($urandom % 3) == 0);
            bit we  = (($urandom % 2) == 0);
            logic [NB-1:0] be = NB'($urandom);
            if (($urandom % 4) == 0) be = '1;
            step(clr, es, t, r, col, we, rand_word(), be, "R2_R9_R10 random");
        end

        finish_run();
    end

endmodule